// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block holds the two configuration dwords of a PCI function's power management capability: a read-only header dword and a control/status dword. It also produces the active-low wake request output. A configuration access engine drives the block through a simple port that carries a dword address, byte enables, write data and a write strobe. Read data comes back combinationally for whatever address is presented.

The control/status dword has three parts. The power-state field is cleared by either reset. The wake status flag and the wake enable flag are sticky, so a PCI reset leaves them alone and only the power-on reset clears them. An internal event pulse sets the status flag whatever the enable flag holds. Software clears the flag by writing a one to it. The wake output is a registered function of the two flags, so it cannot glitch.

Top module: `pm_cap_regs`

## Requirements
- R1: The header dword at byte offset CAP_BASE (default 40h) reads 01h in bits 7:0, 00h in bits 15:8 and 010b in bits 18:16. It reads the D1 support flag in bit 25, the D2 support flag in bit 26 and the wake-support mask in bits 31:27. All other bits read 0. With the default parameters it reads 4802_0001h.
- R2: Writes to the header dword have no effect on what it reads.
- R3: The control/status dword is at CAP_BASE+4 (default 44h). Its bits 31:16, 14:9 and 7:2 always read 0, whatever is written to them. Any other address in the dword space reads 0.
- R4: Bits 1:0 hold the power state (00 = D0, 01 = D1, 10 = D2, 11 = D3hot). A write with byte enable 0 set loads the field. Either reset clears it to 00.
- R5: A power-state write that encodes D1 or D2 while that state is unsupported is ignored, and the field keeps its value. 00 and 11 are always accepted.
- R6: Only the bytes whose byte enable is set are written. Byte 0 carries the power state, and byte 1 carries the enable and status flags.
- R7: An event pulse sets the status flag (bit 15) on the next clock edge, whatever the enable flag holds.
- R8: Writing 1 to bit 15 with byte enable 1 clears the status flag. Writing 0 to it leaves the flag unchanged.
- R9: If an event and a clear of the status flag fall in the same cycle, the status flag stays set.
- R10: The wake output is driven low one clock after both the status and enable flags are 1, and only then. It is high one clock after either flag is 0.
- R11: PCI reset leaves the status flag, the enable flag and the wake output unchanged, and it blocks configuration writes. Power-on reset clears both flags and drives the wake output high.
- R12: Bit 8 is the wake enable flag. It is read/write through byte enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| rst_pci_n | input | 1 | PCI reset, synchronous, active low; clears the power state only |
| cfg_addr | input | 6 | Configuration dword address (byte offset bits 7:2) |
| cfg_wr | input | 1 | Write strobe for the addressed dword |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed dword |
| pme_event | input | 1 | Internal wake event pulse |
| pme_n | output | 1 | Registered active-low wake request |

## Verification
The assertions check on every cycle that the wake output tracks the registered AND of the two flags and that an event always leaves the status flag set. They also check that a clear with no coincident event drops the flag, and that PCI reset neither disturbs the sticky flags nor leaves the power state non-zero. They confirm that the reserved fields of the control dword read zero and that an unsupported power state is never held. Only the bench's scenarios can show byte-enable masking of mixed writes, that writing zero has no effect, that the header ignores writes, and that the flags survive a PCI reset and are then cleared by a power-on reset.

// File: rtl/pmcap_pkg.sv
// Package: shared field positions, power-state encoding and header builder
// for the power management capability registers.
package pmcap_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pwr_state_t;

    localparam int unsigned PS_LSB      = 0;
    localparam int unsigned PS_W        = 2;
    localparam int unsigned EN_BIT      = 8;
    localparam int unsigned ST_BIT      = 15;
    localparam logic [7:0]  CAP_ID_PM   = 8'h01;
    localparam logic [7:0]  CAP_NEXT    = 8'h00;
    localparam logic [2:0]  PM_REV      = 3'b010;

    // Assembles the read-only header dword from its fields.
    function automatic logic [31:0] build_header(
        input logic       d1_sup,
        input logic       d2_sup,
        input logic [4:0] wake_sup
    );
        logic [31:0] h;
        h        = '0;
        h[7:0]   = CAP_ID_PM;
        h[15:8]  = CAP_NEXT;
        h[18:16] = PM_REV;
        h[25]    = d1_sup;
        h[26]    = d2_sup;
        h[31:27] = wake_sup;
        return h;
    endfunction

endpackage

// File: rtl/pm_cap_hdr.sv
// Read-only capability header dword.
// Assumes: the fields are fixed by parameters and no write path exists.
module pm_cap_hdr
    import pmcap_pkg::*;
#(
    parameter bit         D1_SUP   = 1'b0,
    parameter bit         D2_SUP   = 1'b0,
    parameter logic [4:0] WAKE_SUP = 5'b01001
) (
    output logic [31:0] hdr_dw
);
    // Constant header value built from the parameters.
    assign hdr_dw = build_header(D1_SUP, D2_SUP, WAKE_SUP);
endmodule

// File: rtl/pm_state_reg.sv
// Power-state field storage with an acceptance filter for unsupported states.
// Assumes: rst_n already combines both resets; wr_en qualifies byte 0 writes.
module pm_state_reg
    import pmcap_pkg::*;
#(
    parameter bit D1_SUP = 1'b0,
    parameter bit D2_SUP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PS_W-1:0] wr_val,
    output pwr_state_t      state
);
    localparam int unsigned NSTATES = 1 << PS_W;

    logic [NSTATES-1:0] accept;

    // Per-encoding acceptance flags chosen by the support parameters.
    for (genvar g = 0; g < NSTATES; g++) begin : g_accept
        if (g == int'(PS_D1)) begin : g_d1
            assign accept[g] = D1_SUP;
        end else if (g == int'(PS_D2)) begin : g_d2
            assign accept[g] = D2_SUP;
        end else begin : g_fixed
            assign accept[g] = 1'b1;
        end
    end

    // Loads an accepted encoding; either reset returns to D0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_D0;
        end else if (wr_en && accept[wr_val]) begin
            state <= pwr_state_t'(wr_val);
        end
    end
endmodule

// File: rtl/pm_sticky_bits.sv
// Sticky wake status (write-one-to-clear) and wake enable flags.
// Assumes: only the power-on reset reaches here; an event beats a clear.
module pm_sticky_bits (
    input  logic clk,
    input  logic por_n,
    input  logic evt,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_st_bit,
    output logic st_q,
    output logic en_q
);
    logic clr;

    // A clear needs a byte 1 write with a one in the status position.
    assign clr = wr_en && wr_st_bit;

    // Status flag: set by events, cleared by a written one, event wins.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q <= 1'b0;
        end else begin
            st_q <= evt || (st_q && !clr);
        end
    end

    // Enable flag: plain read/write through byte 1.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            en_q <= 1'b0;
        end else if (wr_en) begin
            en_q <= wr_en_bit;
        end
    end
endmodule

// File: rtl/pme_out_drv.sv
// Registered active-low wake output.
// Assumes: the output must not glitch, so it is taken straight from a flop.
module pme_out_drv (
    input  logic clk,
    input  logic por_n,
    input  logic st_q,
    input  logic en_q,
    output logic pme_n
);
    // Drives low only while both flags were set on the previous cycle.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pme_n <= 1'b1;
        end else begin
            pme_n <= !(st_q && en_q);
        end
    end
endmodule

// File: rtl/pm_cap_regs.sv
// Top: power management capability header and control/status registers
// with wake signalling. Assumes one configuration access per cycle and a
// combinational read of the addressed dword.
module pm_cap_regs
    import pmcap_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [7:0]  CAP_BASE = 8'h40,
    parameter bit          D1_SUP   = 1'b0,
    parameter bit          D2_SUP   = 1'b0,
    parameter logic [4:0]  WAKE_SUP = 5'b01001
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pci_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              pme_event,
    output logic              pme_n
);
    localparam logic [ADDR_W-1:0] HDR_DW = ADDR_W'(CAP_BASE >> 2);
    localparam logic [ADDR_W-1:0] CTL_DW = ADDR_W'((CAP_BASE >> 2) + 1);

    logic        any_rst_n;
    logic        wr_ok;
    logic        ctl_sel;
    logic        wr_b0;
    logic        wr_b1;
    logic [31:0] hdr_dw;
    logic [31:0] ctl_dw;
    pwr_state_t  pwr_state;
    logic        pme_status;
    logic        pme_enable;

    // Power state clears on either reset; writes wait for both to release.
    assign any_rst_n = por_n && rst_pci_n;
    assign wr_ok     = cfg_wr && any_rst_n;
    assign ctl_sel   = (cfg_addr == CTL_DW);
    assign wr_b0     = wr_ok && ctl_sel && cfg_be[0];
    assign wr_b1     = wr_ok && ctl_sel && cfg_be[1];

    pm_cap_hdr #(
        .D1_SUP   (D1_SUP),
        .D2_SUP   (D2_SUP),
        .WAKE_SUP (WAKE_SUP)
    ) u_hdr (
        .hdr_dw (hdr_dw)
    );

    pm_state_reg #(
        .D1_SUP (D1_SUP),
        .D2_SUP (D2_SUP)
    ) u_state (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .wr_en  (wr_b0),
        .wr_val (cfg_wdata[PS_LSB +: PS_W]),
        .state  (pwr_state)
    );

    pm_sticky_bits u_sticky (
        .clk       (clk),
        .por_n     (por_n),
        .evt       (pme_event),
        .wr_en     (wr_b1),
        .wr_en_bit (cfg_wdata[EN_BIT]),
        .wr_st_bit (cfg_wdata[ST_BIT]),
        .st_q      (pme_status),
        .en_q      (pme_enable)
    );

    pme_out_drv u_drv (
        .clk   (clk),
        .por_n (por_n),
        .st_q  (pme_status),
        .en_q  (pme_enable),
        .pme_n (pme_n)
    );

    // Control/status dword image; unimplemented fields stay zero.
    always_comb begin
        ctl_dw                      = '0;
        ctl_dw[PS_LSB +: PS_W]      = pwr_state;
        ctl_dw[EN_BIT]              = pme_enable;
        ctl_dw[ST_BIT]              = pme_status;
    end

    // Read mux over the two capability dwords.
    always_comb begin
        if (cfg_addr == HDR_DW) begin
            cfg_rdata = hdr_dw;
        end else if (ctl_sel) begin
            cfg_rdata = ctl_dw;
        end else begin
            cfg_rdata = '0;
        end
    end
endmodule

// File: rtl/pm_cap_chk.sv
// Checker bound to pm_cap_regs: cycle-by-cycle rules on the flags and output.
// Assumes the default dword address of the control register unless overridden.
module pm_cap_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter logic [ADDR_W-1:0] CTL_DW = 6'h11,
    parameter bit D1_SUP = 1'b0,
    parameter bit D2_SUP = 1'b0
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_pci_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              pme_event,
    input logic              pme_n,
    input logic              st_q,
    input logic              en_q,
    input logic [1:0]        ps_q
);
    // R10
    pme_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q && en_q) |=> !pme_n);
    // R10
    pme_high_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(st_q && en_q) |=> pme_n);
    // R7
    evt_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
        pme_event |=> st_q);
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_wr && rst_pci_n && cfg_addr == CTL_DW && cfg_be[1] && cfg_wdata[15]
         && !pme_event) |=> !st_q);
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_pci_n && !pme_event) |=> ($stable(st_q) && $stable(en_q)));
    // R4
    ps_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pci_n |=> (ps_q == 2'b00));
    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_addr == CTL_DW) |-> (cfg_rdata[31:16] == 16'h0 && cfg_rdata[14:9] == 6'h0
                                  && cfg_rdata[7:2] == 6'h0));
    // R5
    ps_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ps_q != 2'b01 || D1_SUP) && (ps_q != 2'b10 || D2_SUP));
endmodule

bind pm_cap_regs pm_cap_chk #(
    .ADDR_W (ADDR_W),
    .CTL_DW (CTL_DW),
    .D1_SUP (D1_SUP),
    .D2_SUP (D2_SUP)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_pci_n (rst_pci_n),
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pme_event (pme_event),
    .pme_n     (pme_n),
    .st_q      (pme_status),
    .en_q      (pme_enable),
    .ps_q      (pwr_state)
);

// File: tb/pm_cap_regs_tb.sv
module pm_cap_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] HDR_A = 6'h10;
    localparam logic [5:0] CTL_A = 6'h11;
    localparam logic [31:0] HDR_EXP = 32'h4802_0001;

    logic        clk = 1'b0;
    logic        por_n, rst_pci_n, cfg_wr, pme_event;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        pme_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_cap_regs u_dut (
        .clk(clk), .por_n(por_n), .rst_pci_n(rst_pci_n), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pme_event(pme_event), .pme_n(pme_n)
    );

    // Vector: write?, byte enables, data, event, requirement, expected ctl, expected pme_n
    typedef struct packed {
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        ev;
        logic [7:0]  req;
        logic [31:0] exp_ctl;
        logic        exp_pme;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'b0001, 32'h0000_0003, 1'b0, 8'd4,  32'h0000_0003, 1'b1}, // R4 D3hot
        '{1'b1, 4'b0001, 32'h0000_0001, 1'b0, 8'd5,  32'h0000_0003, 1'b1}, // R5 D1 refused
        '{1'b1, 4'b0001, 32'h0000_0002, 1'b0, 8'd5,  32'h0000_0003, 1'b1}, // R5 D2 refused
        '{1'b1, 4'b0001, 32'h0000_0000, 1'b0, 8'd4,  32'h0000_0000, 1'b1}, // R4 back to D0
        '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 8'd7,  32'h0000_8000, 1'b1}, // R7 event, en off
        '{1'b1, 4'b0010, 32'h0000_0000, 1'b0, 8'd8,  32'h0000_8000, 1'b1}, // R8 zero no effect
        '{1'b1, 4'b0001, 32'h0000_FFFF, 1'b0, 8'd6,  32'h0000_8003, 1'b1}, // R6 byte0 only
        '{1'b1, 4'b0010, 32'h0000_0100, 1'b0, 8'd12, 32'h0000_8103, 1'b0}, // R12 R10 enable
        '{1'b1, 4'b1110, 32'hFFFF_7EFC, 1'b0, 8'd6,  32'h0000_8003, 1'b1}, // R6 R3 R10
        '{1'b1, 4'b0010, 32'h0000_0100, 1'b0, 8'd10, 32'h0000_8103, 1'b0}, // R10
        '{1'b1, 4'b0010, 32'h0000_8100, 1'b0, 8'd8,  32'h0000_0103, 1'b1}, // R8 clear
        '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 8'd7,  32'h0000_8103, 1'b0}, // R7
        '{1'b1, 4'b0010, 32'h0000_8100, 1'b1, 8'd9,  32'h0000_8103, 1'b0}, // R9 event wins
        '{1'b1, 4'b1111, 32'hFFFF_FFFF, 1'b0, 8'd3,  32'h0000_0103, 1'b1}  // R3 R8
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [5:0] a, input string req, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; rst_pci_n = 1'b0; cfg_wr = 1'b0; pme_event = 1'b0;
        cfg_addr = CTL_A; cfg_be = 4'h0; cfg_wdata = '0;
        tick(); tick(); tick();
        por_n = 1'b1; rst_pci_n = 1'b1;
        tick();
        // R11 reset state, R1 header
        rd_chk(CTL_A, "R11", 32'h0);
        chk("R11", {31'b0, pme_n}, 32'h1);
        rd_chk(HDR_A, "R1", HDR_EXP);
        rd_chk(6'h12, "R3", 32'h0);

        // R2 header write ignored
        cfg_addr = HDR_A; cfg_wr = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'h0000_0000;
        tick();
        cfg_wr = 1'b0;
        tick();
        rd_chk(HDR_A, "R2", HDR_EXP);

        for (int i = 0; i < NV; i++) begin
            cfg_addr = CTL_A; cfg_wr = VECS[i].wr; cfg_be = VECS[i].be;
            cfg_wdata = VECS[i].wd; pme_event = VECS[i].ev;
            tick();
            cfg_wr = 1'b0; pme_event = 1'b0; cfg_be = 4'h0;
            tick();
            rd_chk(CTL_A, $sformatf("R%0d vec%0d ctl", VECS[i].req, i), VECS[i].exp_ctl);
            chk($sformatf("R%0d vec%0d pme_n", VECS[i].req, i), {31'b0, pme_n},
                {31'b0, VECS[i].exp_pme});
        end

        // Set status and enable, power state D3hot, then PCI reset (R11, R4)
        cfg_addr = CTL_A; cfg_wr = 1'b1; cfg_be = 4'b0011; cfg_wdata = 32'h0000_0103;
        pme_event = 1'b1;
        tick();
        cfg_wr = 1'b0; pme_event = 1'b0;
        tick();
        rd_chk(CTL_A, "R10 setup", 32'h0000_8103);
        chk("R10 setup", {31'b0, pme_n}, 32'h0);
        rst_pci_n = 1'b0;
        cfg_wr = 1'b1; cfg_be = 4'b0010; cfg_wdata = 32'h0000_8000; // R11 blocked write
        tick(); tick();
        cfg_wr = 1'b0;
        rd_chk(CTL_A, "R11 pci reset", 32'h0000_8100);
        chk("R11 pci reset pme_n", {31'b0, pme_n}, 32'h0);
        rst_pci_n = 1'b1;
        tick();
        rd_chk(CTL_A, "R4 after pci reset", 32'h0000_8100);
        chk("R11 after pci reset pme_n", {31'b0, pme_n}, 32'h0);

        // Power-on reset clears sticky flags and releases output (R11)
        por_n = 1'b0;
        tick();
        chk("R11 por pme_n", {31'b0, pme_n}, 32'h1);
        por_n = 1'b1;
        tick();
        rd_chk(CTL_A, "R11 por", 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule